// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM. Its read path is registered in two stages, and it has an internal two-bit burst sequencer. A bus master starts an access by pulling either of two address strobes low while the part is selected. The word address is captured at that clock edge. Pulling the advance input low on later cycles steps through the other three words of the aligned four-word block. The mode input chooses a linear or an interleaved step order. Keeping advance high parks the sequencer on its current word.

Writes are controlled by a global write enable, or by a byte-write master enable together with per-byte enables. Reads return data one cycle after the address is registered. A strobe cycle that finds the part unselected disables the outputs on the following cycle. The output-enable pin masks the data outputs without stopping the pipeline behind them.

Top module: `burst_sram`

## Requirements
- R1: When `proc_strobe_n` or `ctrl_strobe_n` is low at a rising edge and the part is selected, `addr` is captured as the burst base, and the burst step count is cleared to 0.
- R2: When `interleave` was 0 at the load edge, the low two address bits follow base+0, base+1, base+2, base+3, taken modulo 4. The upper bits keep the base value.
- R3: When `interleave` was 1 at the load edge, the low two address bits follow base XOR 0, 1, 2 and then 3. The upper bits keep the base value.
- R4: On a cycle with both strobes high and `advance_n` high, the internal address is held. That word is read again, and the write inputs are ignored.
- R5: After the fourth word, the next advance wraps to the base word, and the same order repeats from there.
- R6: Data for the address registered at edge k is on `rdata`, with `data_valid` high, after edge k+1, provided that access was a read.
- R7: The part is selected only when `chip_en_n`=0, `chip_sel_n`=0 and `chip_sel`=1. A strobe cycle with any one of these wrong starts no access.
- R8: After a strobe cycle that finds the part unselected, `data_valid` still reflects the previous access on the next cycle. It is low on the cycle after that.
- R9: When `out_en_n` is high, `data_valid` is low and `rdata` is 0. The burst keeps advancing, so the word after the masked one appears once `out_en_n` returns low.
- R10: On an access cycle with `wr_all_n`=0, all bytes are written. Otherwise, with `wr_bytes_n`=0, byte i is written when `byte_en_n[i]`=0. With `wr_bytes_n`=1, no byte is written, and the cycle is a read. A write cycle gives `data_valid` low one cycle later.
- R11: After synchronous reset, `data_valid` is low and `rdata` is 0.
- R12: `rdata` is 0 whenever `data_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_n | input | 1 | Chip enable, active low |
| chip_sel_n | input | 1 | Second select, active low |
| chip_sel | input | 1 | Third select, active high |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low; high suspends |
| interleave | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_bytes_n | input | 1 | Byte-write master enable, active low |
| byte_en_n | input | BYTES | Per-byte write enables, active low, bit i = byte i |
| out_en_n | input | 1 | Output enable, active low |
| wdata | input | BYTES*BYTE_W | Write data, sampled with the address |
| rdata | output | BYTES*BYTE_W | Read data, 0 when not valid |
| data_valid | output | 1 | Data outputs driven (tri-state enable flag) |

## Verification
The bench builds the block with a 6-bit address, four bytes and 8-bit bytes. This gives 64 words, so random traffic keeps reusing the same four-word blocks. Writes, wrapped bursts and suspended bursts therefore often overlap addresses that were already read. Four byte lanes leave room for byte enables with mixed patterns, which expose a byte written in the wrong lane. The small depth also lets a full preload of known values finish in a few dozen cycles, before the directed burst orders are checked word by word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_LOAD,
    CYC_DESEL,
    CYC_STEP,
    CYC_HOLD
  } cyc_kind_t;

  // low two address bits for a given burst position
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = base ^ step;
    else     r = 2'(base + step);
    return r;
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             chip_en_n,
  input  logic             chip_sel_n,
  input  logic             chip_sel,
  input  logic             advance_n,
  input  logic             active,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [BYTES-1:0] byte_en_n,
  output cyc_kind_t        kind,
  output logic [BYTES-1:0] wr_mask
);

  logic strobe;
  logic selected;
  logic access;

  assign strobe   = !proc_strobe_n || !ctrl_strobe_n;
  assign selected = !chip_en_n && !chip_sel_n && chip_sel;

  always_comb begin
    if (strobe)          kind = selected ? CYC_LOAD : CYC_DESEL;
    else if (!active)    kind = CYC_IDLE;
    else if (!advance_n) kind = CYC_STEP;
    else                 kind = CYC_HOLD;
  end

  assign access = (kind == CYC_LOAD) || (kind == CYC_STEP);

  always_comb begin
    if (!access)         wr_mask = '0;
    else if (!wr_all_n)  wr_mask = '1;
    else if (!wr_bytes_n) wr_mask = ~byte_en_n;
    else                 wr_mask = '0;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        burst_seq,
  output logic              active
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      step_q;
  logic            ilv_q;
  logic            active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi  <= '0;
      base_lo  <= '0;
      step_q   <= '0;
      ilv_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      unique case (kind)
        CYC_LOAD: begin
          base_hi  <= addr[ADDR_W-1:2];
          base_lo  <= addr[1:0];
          step_q   <= '0;
          ilv_q    <= interleave;
          active_q <= 1'b1;
        end
        CYC_DESEL: active_q <= 1'b0;
        CYC_STEP:  step_q   <= 2'(step_q + 2'd1);
        default: ;
      endcase
    end
  end

  assign cur_addr  = {base_hi, burst_low(base_lo, step_q, ilv_q)};
  assign burst_seq = step_q;
  assign active    = active_q;

endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES-1:0]        wr_mask,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  // one narrow array per byte lane so byte-enable RAM maps cleanly
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [WORDS];
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_mask[b]) mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
      q <= mem[addr];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chip_en_n,
  input  logic                    chip_sel_n,
  input  logic                    chip_sel,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    advance_n,
  input  logic                    interleave,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_all_n,
  input  logic                    wr_bytes_n,
  input  logic [BYTES-1:0]        byte_en_n,
  input  logic                    out_en_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    data_valid
);

  localparam int DATA_W = BYTES * BYTE_W;

  cyc_kind_t         kind;
  logic [BYTES-1:0]  acc_mask;
  logic              active;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        burst_seq;

  // stage A: registered access request
  logic              rd_pend;
  logic [BYTES-1:0]  wr_mask_q;
  logic [DATA_W-1:0] wdata_q;
  // stage B: registered output enable and RAM data
  logic              drive_q;
  logic [DATA_W-1:0] ram_q;

  burst_sram_ctrl #(.BYTES(BYTES)) u_ctrl (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_en_n     (chip_en_n),
    .chip_sel_n    (chip_sel_n),
    .chip_sel      (chip_sel),
    .advance_n     (advance_n),
    .active        (active),
    .wr_all_n      (wr_all_n),
    .wr_bytes_n    (wr_bytes_n),
    .byte_en_n     (byte_en_n),
    .kind          (kind),
    .wr_mask       (acc_mask)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .addr       (addr),
    .interleave (interleave),
    .cur_addr   (cur_addr),
    .burst_seq  (burst_seq),
    .active     (active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      wr_mask_q <= '0;
    end else begin
      unique case (kind)
        CYC_LOAD, CYC_STEP: begin
          rd_pend   <= (acc_mask == '0);
          wr_mask_q <= acc_mask;
        end
        CYC_HOLD: begin
          rd_pend   <= 1'b1;
          wr_mask_q <= '0;
        end
        default: begin
          rd_pend   <= 1'b0;
          wr_mask_q <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    wdata_q <= wdata;
  end

  sram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_ram (
    .clk     (clk),
    .addr    (cur_addr),
    .wr_mask (wr_mask_q),
    .wdata   (wdata_q),
    .rdata   (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_pend;
  end

  assign data_valid = drive_q && !out_en_n;
  assign rdata      = data_valid ? ram_q : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_n,
  input logic              chip_sel_n,
  input logic              chip_sel,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              advance_n,
  input logic              wr_all_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        burst_seq,
  input logic              active,
  input logic              rd_pend,
  input logic              data_valid
);

  logic strobe, sel;
  assign strobe = !proc_strobe_n || !ctrl_strobe_n;
  assign sel    = !chip_en_n && !chip_sel_n && chip_sel;

  p_load_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe && sel) |=> (cur_addr == $past(addr) && burst_seq == 2'd0));

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobe && active && advance_n) |=> $stable(cur_addr));

  p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobe && active && !advance_n) |=> burst_seq == 2'($past(burst_seq) + 2'd1));

  p_valid_src_r6: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(rd_pend));

  p_desel_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe && !sel) |=> ##1 !data_valid);

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe && sel && !wr_all_n) |=> ##1 !data_valid);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .chip_en_n     (chip_en_n),
  .chip_sel_n    (chip_sel_n),
  .chip_sel      (chip_sel),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .advance_n     (advance_n),
  .wr_all_n      (wr_all_n),
  .addr          (addr),
  .cur_addr      (cur_addr),
  .burst_seq     (burst_seq),
  .active        (active),
  .rd_pend       (rd_pend),
  .data_valid    (data_valid)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic chip_en_n, chip_sel_n, chip_sel;
  logic proc_strobe_n, ctrl_strobe_n, advance_n, interleave;
  logic [AW-1:0] addr;
  logic wr_all_n, wr_bytes_n;
  logic [NB-1:0] byte_en_n;
  logic out_en_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic data_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .chip_sel_n(chip_sel_n),
    .chip_sel(chip_sel), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n),
    .interleave(interleave), .addr(addr), .wr_all_n(wr_all_n),
    .wr_bytes_n(wr_bytes_n), .byte_en_n(byte_en_n), .out_en_n(out_en_n),
    .wdata(wdata), .rdata(rdata), .data_valid(data_valid)
  );

  // reference model state
  logic [DW-1:0] ref_mem [WORDS];
  logic          m_active, m_ilv, m_rd, m_en;
  logic [AW-1:0] m_base;
  logic [1:0]    m_seq;
  logic [NB-1:0] m_wr;
  logic [DW-1:0] m_wdata, m_dout;

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hC0DE0000 + 32'(a) * 32'd4099;
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] b,
                                            input logic [1:0] s, input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ s) : 2'(b[1:0] + s);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [AW-1:0] cur;
    logic strobe, sel, access;
    logic [NB-1:0] mask;
    cur    = addr_of(m_base, m_seq, m_ilv);
    m_en   = m_rd;
    m_dout = ref_mem[cur];
    for (int b = 0; b < NB; b++)
      if (m_wr[b]) ref_mem[cur][b*BW +: BW] = m_wdata[b*BW +: BW];
    strobe = !proc_strobe_n || !ctrl_strobe_n;
    sel    = !chip_en_n && !chip_sel_n && chip_sel;
    access = 1'b0;
    m_rd = 1'b0; m_wr = '0;
    if (strobe) begin
      if (sel) begin
        m_active = 1'b1; m_base = addr; m_seq = 2'd0; m_ilv = interleave; access = 1'b1;
      end else m_active = 1'b0;
    end else if (m_active) begin
      if (!advance_n) begin m_seq = 2'(m_seq + 2'd1); access = 1'b1; end
      else m_rd = 1'b1;
    end
    if (access) begin
      mask = !wr_all_n ? '1 : (!wr_bytes_n ? ~byte_en_n : '0);
      m_wr = mask; m_wdata = wdata; m_rd = (mask == '0);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    logic ev;
    @(posedge clk);
    if (!rst) model_step();
    @(negedge clk);
    ev = m_en && !out_en_n;
    chk("R6 R12 valid", {31'd0, data_valid}, {31'd0, ev});
    chk("R6 R10 data", rdata, ev ? m_dout : '0);
  endtask

  task automatic idle_in();
    proc_strobe_n = 1; ctrl_strobe_n = 1; advance_n = 1; interleave = 0;
    chip_en_n = 0; chip_sel_n = 0; chip_sel = 1;
    wr_all_n = 1; wr_bytes_n = 1; byte_en_n = '1; out_en_n = 0;
    addr = '0; wdata = '0;
  endtask

  // load base, then advance n times, checking each returned word
  task automatic burst(input string req, input int base, input logic ilv,
                       input logic use_ctrl, input int exp [5]);
    idle_in();
    interleave = ilv; addr = AW'(base);
    if (use_ctrl) ctrl_strobe_n = 0; else proc_strobe_n = 0;
    tick();
    idle_in();
    advance_n = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(req, rdata, pat(exp[i]));
    end
    idle_in();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] old;
    void'($urandom(32'd20240611));
    idle_in();
    m_active = 0; m_ilv = 0; m_rd = 0; m_en = 0; m_base = '0; m_seq = '0;
    m_wr = '0; m_wdata = '0; m_dout = '0;
    for (int a = 0; a < WORDS; a++) ref_mem[a] = 'x;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    chk("R11 valid", {31'd0, data_valid}, 32'd0);
    chk("R11 rdata", rdata, '0);

    // R10: preload with global write
    for (int a = 0; a < WORDS; a++) begin
      idle_in(); proc_strobe_n = 0; addr = AW'(a); wr_all_n = 0; wdata = pat(a);
      tick();
    end
    idle_in(); chip_en_n = 1; proc_strobe_n = 0; tick();
    idle_in(); tick();

    // R2 R5: linear from 6: 6,7,4,5 then wraps to 6
    burst("R2 R5 linear", 6, 1'b0, 1'b0, '{6, 7, 4, 5, 6});
    // R3 R1: interleaved from 9 via controller strobe: 9,8,11,10,9
    burst("R3 R1 interleaved", 9, 1'b1, 1'b1, '{9, 8, 11, 10, 9});
    // R3 R5: interleaved from 14: 14,15,12,13,14
    burst("R3 R5 interleaved", 14, 1'b1, 1'b0, '{14, 15, 12, 13, 14});

    // R4: suspend for three cycles then resume
    idle_in(); proc_strobe_n = 0; addr = 6'd17; tick();
    idle_in(); advance_n = 0; tick(); chk("R4 first", rdata, pat(17));
    idle_in(); wr_all_n = 0; wdata = 32'hDEADBEEF; // ignored while suspended
    tick(); chk("R4 step", rdata, pat(18));
    tick(); chk("R4 hold", rdata, pat(18));
    tick(); chk("R4 hold", rdata, pat(18));
    idle_in(); advance_n = 0;
    tick(); chk("R4 hold end", rdata, pat(18));
    tick(); chk("R4 resume", rdata, pat(19));
    tick(); chk("R4 R5 wrap", rdata, pat(16));

    // R8: deselect latency
    idle_in(); proc_strobe_n = 0; addr = 6'd30; tick();
    idle_in(); proc_strobe_n = 0; chip_en_n = 1; tick();
    chk("R8 still valid", {31'd0, data_valid}, 32'd1);
    chk("R8 prior data", rdata, pat(30));
    idle_in(); tick();
    chk("R8 disabled", {31'd0, data_valid}, 32'd0);

    // R7: each wrong select blocks the access
    for (int k = 0; k < 3; k++) begin
      idle_in(); ctrl_strobe_n = 0; addr = 6'd33;
      if (k == 0) chip_en_n = 1; else if (k == 1) chip_sel_n = 1; else chip_sel = 0;
      tick();
      idle_in(); tick();
      chk("R7 not selected", {31'd0, data_valid}, 32'd0);
    end
    idle_in(); ctrl_strobe_n = 0; addr = 6'd33; tick();
    idle_in(); tick();
    chk("R7 selected", rdata, pat(33));

    // R9: output enable masks one word, burst continues
    idle_in(); proc_strobe_n = 0; addr = 6'd40; tick();
    idle_in(); advance_n = 0; tick(); chk("R9 before", rdata, pat(40));
    out_en_n = 1; tick();
    chk("R9 masked valid", {31'd0, data_valid}, 32'd0);
    chk("R9 masked data", rdata, '0);
    out_en_n = 0; tick(); chk("R9 after", rdata, pat(42));

    // R10: byte write to bytes 0 and 2 (byte_en_n bit i = byte i)
    old = pat(20);
    idle_in(); proc_strobe_n = 0; addr = 6'd20; wr_bytes_n = 0;
    byte_en_n = 4'b1010; wdata = 32'hAABBCCDD; tick();
    idle_in(); proc_strobe_n = 0; addr = 6'd20; tick();
    chk("R10 write no valid", {31'd0, data_valid}, 32'd0);
    idle_in(); tick();
    chk("R10 byte merge", rdata, (old & 32'hFF00FF00) | (32'hAABBCCDD & 32'h00FF00FF));
    // R10: byte enables without master enable: read, no write
    idle_in(); proc_strobe_n = 0; addr = 6'd21; byte_en_n = 4'b0000;
    wdata = 32'hFFFFFFFF; tick();
    idle_in(); proc_strobe_n = 0; addr = 6'd21; tick();
    chk("R10 no master read", rdata, pat(21));
    idle_in(); tick();
    chk("R10 no master kept", rdata, pat(21));

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      proc_strobe_n = ($urandom % 6) != 0;
      ctrl_strobe_n = ($urandom % 6) != 0;
      chip_en_n  = ($urandom % 8) == 0;
      chip_sel_n = ($urandom % 8) == 0;
      chip_sel   = ($urandom % 8) != 0;
      advance_n  = $urandom % 2;
      interleave = $urandom % 2;
      addr       = AW'($urandom);
      wr_all_n   = ($urandom % 8) != 0;
      wr_bytes_n = ($urandom % 4) != 0;
      byte_en_n  = NB'($urandom);
      out_en_n   = ($urandom % 10) == 0;
      wdata      = $urandom;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule